// File: doc/BRIEF.md
# Memory Decoder Control Register File

This block holds the programming state for up to four memory address decoders. It also holds a read-only capability word and a small global control word. Software reaches every register through a simple 32-bit little-endian request port. Each request carries a valid, a write flag, a wide-access flag, a byte offset and write data. A read returns its data one cycle after the request.

Every write passes through a per-register write mask. Bits outside the mask keep the value they already hold, so read-only fields cannot be changed from the port. A write to a decoder control word also runs a commit handshake in the same cycle. The committed status follows the commit bit that was written, and the error status is cleared on every such write.

Register map, as 32-bit words at byte offsets:
- 0x00: capability word.
- 0x04: global control word.
- Decoder n starts at 0x10 + n*0x20. Its registers sit at these offsets from that start:
  - +0x00: base low
  - +0x04: base high
  - +0x08: size low
  - +0x0C: size high
  - +0x10: control
  - +0x14: target list low
  - +0x18: target list high

Any other offset is unmapped.

Top module: `mdec_regfile`

## Requirements
- R1: On reset, the capability word takes its fixed value and every other register reads 0, including the global enable.
- R2: The capability word reads as follows and ignores writes:
  - bits 3:0: decoder count code (1 decoder gives 0, 2 give 1, 4 give 2)
  - bits 7:4: target count, value 1
  - bit 8: 256 B interleave supported, value 1
  - bit 9: 4 KB interleave supported, value 1
  - all other bits: 0
  - With four decoders the word is 0x00000312.
- R3: A write stores (wdata AND mask) OR (old AND NOT mask).
- R4: The global control word is writable in bits 1:0 only; bits 31:2 read 0.
- R5: Base low and size low are writable in bits 31:28 only. Base high and size high are fully writable.
- R6: Target list low is writable in bits 31:28 only when the ENDPOINT parameter is 1, and fully writable when it is 0. Target list high is fully writable.
- R7: The decoder control word has write mask 0x13FF, with commit at bit 9, committed at bit 10 and error at bit 11. Writing commit as 1 stores committed = 1 and error = 0.
- R8: Writing commit as 0 to a decoder control word stores committed = 0 and error = 0.
- R9: A wide (8-byte) access or an offset that is not 4-byte aligned reads 0 and writes nothing.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.
- R11: rsp_valid_o is high exactly in the cycle after a read request. The data it carries reflects every write accepted in an earlier cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 8-byte access (not serviced) |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The checker infers the kind of register behind each response from the offset captured at the read request. It therefore relies on req_addr_i and req_wide_i being stable and meaningful whenever req_valid_i is high, and on one request per cycle at most. The bench drives each request for a single cycle on the falling edge. It holds the strobe low between requests and keeps every offset inside the 8-bit space the checker decodes. Unaligned, wide and unmapped offsets are chosen on purpose, so that these kinds of access fall under the assertions as well.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_CAP, RK_GCTL, RK_BLO, RK_BHI, RK_SLO, RK_SHI, RK_CTRL, RK_TLO, RK_THI
  } reg_kind_e;

  localparam int CTRL_COMMIT_BIT    = 9;
  localparam int CTRL_COMMITTED_BIT = 10;
  localparam int CTRL_ERR_BIT       = 11;
  localparam int DEC_BASE_WORD      = 4;
  localparam int DEC_STRIDE_WORDS   = 8;

  function automatic reg_kind_e kind_of(int unsigned widx, int unsigned num_dec);
    reg_kind_e k;
    k = RK_NONE;
    if (widx == 0) k = RK_CAP;
    else if (widx == 1) k = RK_GCTL;
    else if (widx >= DEC_BASE_WORD && widx < DEC_BASE_WORD + num_dec * DEC_STRIDE_WORDS) begin
      case ((widx - DEC_BASE_WORD) % DEC_STRIDE_WORDS)
        0: k = RK_BLO;
        1: k = RK_BHI;
        2: k = RK_SLO;
        3: k = RK_SHI;
        4: k = RK_CTRL;
        5: k = RK_TLO;
        6: k = RK_THI;
        default: k = RK_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic [31:0] mask_of(reg_kind_e k, bit endpoint);
    case (k)
      RK_GCTL:              return 32'h0000_0003;
      RK_BLO, RK_SLO:       return 32'hF000_0000;
      RK_BHI, RK_SHI, RK_THI: return 32'hFFFF_FFFF;
      RK_CTRL:              return 32'h0000_13FF;
      RK_TLO:               return endpoint ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default:              return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] dec_count_enc(int unsigned n);
    case (n)
      1: return 4'h0;
      2: return 4'h1;
      4: return 4'h2;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [31:0] cap_word(int unsigned n);
    return {22'b0, 1'b1, 1'b1, 4'd1, dec_count_enc(n)};
  endfunction

  function automatic logic [31:0] reset_of(reg_kind_e k, int unsigned n);
    return (k == RK_CAP) ? cap_word(n) : 32'h0;
  endfunction

endpackage

// File: rtl/mdec_addr_dec.sv
module mdec_addr_dec
  import mdec_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_DEC = 4,
  localparam int WIDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic [WIDX_W-1:0] widx_o,
  output reg_kind_e         kind_o,
  output logic              ok_o
);
  always_comb begin
    widx_o = addr_i[ADDR_W-1:2];
    kind_o = kind_of(32'(widx_o), NUM_DEC);
    ok_o   = !wide_i && (addr_i[1:0] == 2'b00) && (kind_o != RK_NONE);
  end
endmodule

// File: rtl/mdec_wr_merge.sv
module mdec_wr_merge
  import mdec_pkg::*;
(
  input  logic [31:0] old_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] mask_i,
  input  logic        is_ctrl_i,
  output logic [31:0] new_o
);
  always_comb begin
    new_o = (wdata_i & mask_i) | (old_i & ~mask_i);
    if (is_ctrl_i) begin
      // commit handshake completes immediately
      new_o[CTRL_COMMITTED_BIT] = new_o[CTRL_COMMIT_BIT];
      new_o[CTRL_ERR_BIT]       = 1'b0;
    end
  end
endmodule

// File: rtl/mdec_reg_slot.sv
module mdec_reg_slot #(
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] d_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/mdec_regfile.sv
module mdec_regfile
  import mdec_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_DEC  = 4,
  parameter bit ENDPOINT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_wide_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int WORDS  = DEC_BASE_WORD + NUM_DEC * DEC_STRIDE_WORDS;

  logic [WIDX_W-1:0] widx;
  reg_kind_e         kind;
  logic              ok;
  logic [31:0]       q [WORDS];
  logic [31:0]       cur, merged;
  logic              wr_fire, rd_fire;

  mdec_addr_dec #(.ADDR_W(ADDR_W), .NUM_DEC(NUM_DEC)) u_dec (
    .addr_i (req_addr_i),
    .wide_i (req_wide_i),
    .widx_o (widx),
    .kind_o (kind),
    .ok_o   (ok)
  );

  always_comb begin
    cur = 32'h0;
    for (int i = 0; i < WORDS; i++) begin
      if (widx == WIDX_W'(i)) cur = q[i];
    end
  end

  mdec_wr_merge u_merge (
    .old_i     (cur),
    .wdata_i   (req_wdata_i),
    .mask_i    (mask_of(kind, ENDPOINT)),
    .is_ctrl_i (kind == RK_CTRL),
    .new_o     (merged)
  );

  assign wr_fire = req_valid_i && req_write_i && ok;
  assign rd_fire = req_valid_i && !req_write_i;

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    localparam reg_kind_e SK = kind_of(g, NUM_DEC);
    if (SK == RK_NONE) begin : g_hole
      assign q[g] = 32'h0;
    end else begin : g_reg
      mdec_reg_slot #(.RST_VAL(reset_of(SK, NUM_DEC))) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_fire && (widx == WIDX_W'(g))),
        .d_i    (merged),
        .q_o    (q[g])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= 32'h0;
    end else begin
      rsp_valid_o <= rd_fire;
      rsp_rdata_o <= (rd_fire && ok) ? cur : 32'h0;
    end
  end
endmodule

// File: rtl/mdec_regfile_chk.sv
module mdec_regfile_chk
  import mdec_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_DEC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              req_wide_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [31:0]       rsp_rdata_o
);
  logic      rd_q, rd_bad_q;
  reg_kind_e rd_kind_q;
  reg_kind_e req_kind;

  assign req_kind = kind_of(32'(req_addr_i[ADDR_W-1:2]), NUM_DEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      rd_bad_q  <= 1'b0;
      rd_kind_q <= RK_NONE;
    end else begin
      rd_q      <= req_valid_i && !req_write_i;
      rd_bad_q  <= req_wide_i || (req_addr_i[1:0] != 2'b00) || (req_kind == RK_NONE);
      rd_kind_q <= req_kind;
    end
  end

  a_r11_rsp_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i |=> rsp_valid_o);
  a_r11_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rd_q);
  // R9 and R10: wide, unaligned and unmapped reads return zero
  a_r9_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rd_bad_q |-> rsp_rdata_o == 32'h0);
  a_r2_cap_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rd_bad_q && rd_kind_q == RK_CAP |-> rsp_rdata_o == cap_word(NUM_DEC));
  a_r4_gctl_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rd_bad_q && rd_kind_q == RK_GCTL |-> rsp_rdata_o[31:2] == '0);
  a_r5_low_regs_upper_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rd_bad_q && (rd_kind_q == RK_BLO || rd_kind_q == RK_SLO)
      |-> rsp_rdata_o[27:0] == '0);
  // R7 and R8: committed mirrors commit, error always clear
  a_r7_ctrl_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rd_bad_q && rd_kind_q == RK_CTRL
      |-> !rsp_rdata_o[CTRL_ERR_BIT] &&
          (rsp_rdata_o[CTRL_COMMITTED_BIT] == rsp_rdata_o[CTRL_COMMIT_BIT]));
endmodule

bind mdec_regfile mdec_regfile_chk #(.ADDR_W(ADDR_W), .NUM_DEC(NUM_DEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_wide_i  (req_wide_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o)
);

// File: tb/mdec_regfile_tb.sv
module mdec_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_wide_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mdec_regfile #(.ADDR_W(8), .NUM_DEC(4), .ENDPOINT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_wide_i(req_wide_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;  // write data or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'd2}, '{1'b0, 8'h00, 32'h0000_0312, 4'd2},  // R2
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 4'd4}, '{1'b0, 8'h04, 32'h0000_0003, 4'd4},  // R4
    '{1'b1, 8'h04, 32'hFFFF_FFFD, 4'd4}, '{1'b0, 8'h04, 32'h0000_0001, 4'd4},  // R4
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 4'd5}, '{1'b0, 8'h10, 32'hF000_0000, 4'd5},  // R5
    '{1'b1, 8'h14, 32'h1234_5678, 4'd5}, '{1'b0, 8'h14, 32'h1234_5678, 4'd5},  // R5
    '{1'b1, 8'h38, 32'hABCD_EF01, 4'd5}, '{1'b0, 8'h38, 32'hA000_0000, 4'd5},  // R5
    '{1'b1, 8'h3C, 32'h5A5A_5A5A, 4'd5}, '{1'b0, 8'h3C, 32'h5A5A_5A5A, 4'd5},  // R5
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 4'd6}, '{1'b0, 8'h24, 32'hF000_0000, 4'd6},  // R6
    '{1'b1, 8'h28, 32'hC3C3_C3C3, 4'd6}, '{1'b0, 8'h28, 32'hC3C3_C3C3, 4'd6},  // R6
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 4'd7}, '{1'b0, 8'h20, 32'h0000_17FF, 4'd7},  // R7
    '{1'b1, 8'h20, 32'h0000_0DFF, 4'd8}, '{1'b0, 8'h20, 32'h0000_01FF, 4'd8},  // R8
    '{1'b1, 8'h80, 32'h0000_0200, 4'd7}, '{1'b0, 8'h80, 32'h0000_0600, 4'd7},  // R7
    '{1'b1, 8'h50, 32'h7FFF_FFFF, 4'd3}, '{1'b0, 8'h50, 32'h7000_0000, 4'd3},  // R3
    '{1'b1, 8'h2C, 32'hFFFF_FFFF, 4'd10}, '{1'b0, 8'h2C, 32'h0000_0000, 4'd10}, // R10
    '{1'b0, 8'h08, 32'h0000_0000, 4'd10}, '{1'b0, 8'hFC, 32'h0000_0000, 4'd10}, // R10
    '{1'b0, 8'h80, 32'h0000_0600, 4'd10}                                        // R10 hole write left dec3 intact
  };

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr_op(input logic [7:0] a, input logic [31:0] d, input logic wide);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_wide_i = wide; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0; req_wide_i = 1'b0;
  endtask

  task automatic rd_op(input logic [7:0] a, input logic wide, output logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_wide_i = wide; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0; req_wide_i = 1'b0;
    chk(11, {31'b0, rsp_valid_o}, 32'h1);  // R11 response one cycle after request
    d = rsp_rdata_o;
  endtask

  task automatic check_defaults();
    logic [31:0] d;
    rd_op(8'h00, 1'b0, d); chk(1, d, 32'h0000_0312);  // R1
    rd_op(8'h04, 1'b0, d); chk(1, d, 32'h0);          // R1
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 7; k++) begin
        rd_op(8'(8'h10 + n * 32 + k * 4), 1'b0, d); chk(1, d, 32'h0);
      end
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(11, {31'b0, rsp_valid_o}, 32'h0);  // R11 idle
    check_defaults();

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr_op(VECS[i].addr, VECS[i].data, 1'b0);
      else begin
        rd_op(VECS[i].addr, 1'b0, d);
        chk(int'(VECS[i].req), d, VECS[i].data);
      end
    end

    // R9: wide and unaligned accesses
    wr_op(8'h14, 32'h0, 1'b1);
    rd_op(8'h14, 1'b0, d); chk(9, d, 32'h1234_5678);
    rd_op(8'h14, 1'b1, d); chk(9, d, 32'h0);
    wr_op(8'h15, 32'h0, 1'b0);
    rd_op(8'h14, 1'b0, d); chk(9, d, 32'h1234_5678);
    rd_op(8'h15, 1'b0, d); chk(9, d, 32'h0);

    // R11: read right after write sees the new value
    wr_op(8'h1C, 32'hDEAD_BEEF, 1'b0);
    rd_op(8'h1C, 1'b0, d); chk(11, d, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(11, {31'b0, rsp_valid_o}, 32'h0);

    // R8: uncommit after commit
    wr_op(8'h80, 32'h0, 1'b0);
    rd_op(8'h80, 1'b0, d); chk(8, d, 32'h0);

    // R1: reset in mid-run restores defaults
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    check_defaults();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule